// File: doc/BRIEF.md
# Hot-Plug Slot Event Register Block

This block holds the control and status state for one hot-plug slot. It samples four asynchronous slot sensors: the attention button, the power-fault flag, the retention-latch position and the active-low card-present pin. Each passes through a synchroniser. Edges on these sensors, plus a command-complete pulse from the slot controller, are latched as sticky event bits. Software clears an event bit by writing a 1 to it.

A control register holds the following fields:
- a per-event notification enable for each of the five events;
- a global notification enable;
- two 2-bit indicator fields;
- a slot main-power request.

The interrupt line is a level. It stays high while the global enable is set and any event bit that is individually enabled is pending.

Any write that changes the indicator or power fields is a command. It clears a ready flag, and the flag returns when the slot controller signals completion. That completion only means a new command can be accepted. It says nothing about whether the previous action has finished.

If the retention latch opens while main power is on, the block clears the power request by itself and pulses a forced power-off output.

Software uses a small register port. Address 0 is the control register and address 1 is the status register. Writes take effect at the clock edge. Reads return data one cycle later.

Top module: `hpslot_regs`

## Requirements
- R1: After reset, the control register reads 0 and the status register reads 0x0080 (ready set, no events, latch closed, no card). `irq`, `slot_pwr_en` and `pwr_force_off` are low.
- R2: A rising edge on `btn_i` sets status bit 0. A rising edge on `pfault_i` sets status bit 1. The bit is set SYNC_STAGES+1 cycles after the edge is sampled. Holding the input high does not set the bit again.
- R3: Either edge of `mrl_open_i` sets status bit 2, and either edge of `prsnt_n_i` sets status bit 3. Status bit 5 shows the synchronised latch level (1 = open). Status bit 6 shows card presence, which is the inverse of the active-low `prsnt_n_i`.
- R4: A one-cycle `cmd_done_i` pulse sets status bit 4 (command completed) and status bit 7 (ready).
- R5: Status bits [4:0] are sticky. Writing 1 to a bit at address 1 clears it, and writing 0 leaves it unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R6: `irq` is registered. It is high when control bit 5 (global enable) is set and some status bit i in [4:0] is set with control bit i set. It stays high as long as that holds.
- R7: A write to address 0 stores bits [10:0], and bits above 10 read as 0. If the write changes bits [10:6], status bit 7 clears until `cmd_done_i` arrives. A write that leaves bits [10:6] unchanged keeps bit 7. `pwr_ind` shows control bits [7:6] and `attn_ind` shows control bits [9:8].
- R8: `slot_pwr_en` and status bit 8 show control bit 10. A synchronised opening of the latch while bit 10 is set clears bit 10 and pulses `pwr_force_off` high for exactly one cycle. An opening while power is off produces no pulse.
- R9: Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read. Addresses 2 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Attention button, high while pressed (asynchronous) |
| pfault_i | input | 1 | Power fault flag, high on fault (asynchronous) |
| mrl_open_i | input | 1 | Retention latch sensor, high when open (asynchronous) |
| prsnt_n_i | input | 1 | Card present, low when a card is inserted (asynchronous) |
| cmd_done_i | input | 1 | Slot controller ready for a new command, one-cycle pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |
| slot_pwr_en | output | 1 | Slot main power enable |
| pwr_force_off | output | 1 | One-cycle pulse when power is cut by a latch opening |
| pwr_ind | output | 2 | Power indicator state |
| attn_ind | output | 2 | Attention indicator state |

## Verification
The bench builds the block with SYNC_STAGES = 3, not the default 2. With that setting the edge-to-event latency comes out as four cycles rather than three, and the reference model must track a deeper delay line. This catches any pipeline that hard-codes two stages. ADDR_W is 2, so the unused addresses 2 and 3 can be exercised, and DATA_W is 16, so the zero bits above the fields become visible. Directed sequences cover two cases: a clear arriving in the same cycle as a new event, and a latch opening both with power on and with power off.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int EV_N   = 5;
  localparam int EV_BTN = 0;
  localparam int EV_PFL = 1;
  localparam int EV_MRL = 2;
  localparam int EV_PRS = 3;
  localparam int EV_CMD = 4;
  localparam int CT_W   = 11;
  localparam int ST_W   = 9;

  // sensor lane order inside the synchroniser
  localparam int SN_N   = 4;
  localparam int SN_BTN = 0;
  localparam int SN_PFL = 1;
  localparam int SN_MRL = 2;
  localparam int SN_PRS = 3;

  typedef struct packed {
    logic            pwr;   // bit 10
    logic [1:0]      aind;  // bits 9:8
    logic [1:0]      pind;  // bits 7:6
    logic            glb;   // bit 5
    logic [EV_N-1:0] en;    // bits 4:0
  } ctrl_t;
endpackage

// File: rtl/hp_sync_edge.sv
module hp_sync_edge #(
  parameter int              N      = 4,
  parameter int              STAGES = 2,
  parameter logic [N-1:0]    IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= {STAGES{IDLE[i]}};
        prev  <= IDLE[i];
      end else begin
        chain[0] <= raw_i[i];
        for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        prev <= chain[STAGES-1];
      end
    end

    assign lvl_o[i]  = chain[STAGES-1];
    assign rise_o[i] = chain[STAGES-1] & ~prev;
    assign fall_o[i] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/hp_evt_status.sv
module hp_evt_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] ev_q;

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= (ev_q & ~clr_i) | set_i;
  end

  assign ev_o = ev_q;

  // R5
  evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(ev_q) & ~ev_q & ~$past(clr_i)) == '0));

  // R5
  evt_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_i & ~ev_q) != '0) |=> ((ev_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
  import hp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [CT_W-1:0] wdata_i,
  input  logic            mrl_rise_i,
  input  logic            cmd_done_i,
  output ctrl_t           ctrl_o,
  output logic            ready_o,
  output logic            force_off_o
);
  ctrl_t ctrl_q, wr_val, ctrl_nxt;
  logic  ready_q, force_q, cmd_issue, cut;

  always_comb begin
    wr_val    = ctrl_t'(wdata_i);
    cmd_issue = wr_i && ((wr_val.pwr  != ctrl_q.pwr)  ||
                         (wr_val.aind != ctrl_q.aind) ||
                         (wr_val.pind != ctrl_q.pind));
    cut       = mrl_rise_i && ctrl_q.pwr;
    ctrl_nxt  = wr_i ? wr_val : ctrl_q;
    if (cut) ctrl_nxt.pwr = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ready_q <= 1'b1;
      force_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      force_q <= cut;
      if (cmd_issue)       ready_q <= 1'b0;
      else if (cmd_done_i) ready_q <= 1'b1;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign ready_o     = ready_q;
  assign force_off_o = force_q;

  // R7
  ready_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(cmd_done_i));

  // R8
  pwr_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (mrl_rise_i && ctrl_q.pwr) |=> (!ctrl_q.pwr && force_q));

  // R8
  force_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    force_q |=> !force_q);
endmodule

// File: rtl/hpslot_regs.sv
module hpslot_regs
  import hp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn_i,
  input  logic              pfault_i,
  input  logic              mrl_open_i,
  input  logic              prsnt_n_i,
  input  logic              cmd_done_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              slot_pwr_en,
  output logic              pwr_force_off,
  output logic [1:0]        pwr_ind,
  output logic [1:0]        attn_ind
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [SN_N-1:0]   SN_IDLE = SN_N'(1) << SN_PRS;

  logic [SN_N-1:0] raw, lvl, rise, fall;
  logic [EV_N-1:0] ev_set, ev_clr, ev;
  ctrl_t           ctrl;
  logic            ready;
  logic [ST_W-1:0] stat;
  logic [DATA_W-1:0] rdata_q;
  logic            irq_q;

  assign raw = {prsnt_n_i, mrl_open_i, pfault_i, btn_i};

  hp_sync_edge #(.N(SN_N), .STAGES(SYNC_STAGES), .IDLE(SN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .raw_i(raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_BTN] = rise[SN_BTN];
    ev_set[EV_PFL] = rise[SN_PFL];
    ev_set[EV_MRL] = rise[SN_MRL] | fall[SN_MRL];
    ev_set[EV_PRS] = rise[SN_PRS] | fall[SN_PRS];
    ev_set[EV_CMD] = cmd_done_i;
    ev_clr = (wr_en && addr == A_STAT) ? wdata[EV_N-1:0] : '0;
  end

  hp_evt_status #(.N(EV_N)) u_evt (
    .clk(clk), .rst(rst), .set_i(ev_set), .clr_i(ev_clr), .ev_o(ev)
  );

  hp_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst),
    .wr_i(wr_en && addr == A_CTRL),
    .wdata_i(wdata[CT_W-1:0]),
    .mrl_rise_i(rise[SN_MRL]),
    .cmd_done_i(cmd_done_i),
    .ctrl_o(ctrl), .ready_o(ready), .force_off_o(pwr_force_off)
  );

  assign stat = {ctrl.pwr, ready, ~lvl[SN_PRS], lvl[SN_MRL], ev};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= ctrl.glb & |(ev & ctrl.en);
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata_q <= DATA_W'(ctrl);
          A_STAT:  rdata_q <= DATA_W'(stat);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata       = rdata_q;
  assign irq         = irq_q;
  assign slot_pwr_en = ctrl.pwr;
  assign pwr_ind     = ctrl.pind;
  assign attn_ind    = ctrl.aind;

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(ctrl.glb) && ($past(ev & ctrl.en) != '0)));

  // R3
  mrl_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl[SN_MRL] != $past(lvl[SN_MRL])) |=> ev[EV_MRL]);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata_q));
endmodule

// File: tb/sim_hpslot_regs.sv
module sim_hpslot_regs;
  localparam int SS = 3;
  localparam int AW = 2;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic btn_i = 0, pfault_i = 0, mrl_open_i = 0, prsnt_n_i = 1, cmd_done_i = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq, slot_pwr_en, pwr_force_off;
  logic [1:0] pwr_ind, attn_ind;

  int checks = 0, errors = 0, force_cnt = 0;

  always #5 clk = ~clk;

  hpslot_regs #(.SYNC_STAGES(SS), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .btn_i(btn_i), .pfault_i(pfault_i),
    .mrl_open_i(mrl_open_i), .prsnt_n_i(prsnt_n_i), .cmd_done_i(cmd_done_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .slot_pwr_en(slot_pwr_en), .pwr_force_off(pwr_force_off),
    .pwr_ind(pwr_ind), .attn_ind(attn_ind)
  );

  // behavioural reference model
  logic [3:0]  rawq[$];
  logic [3:0]  m_s = 4'b1000, m_p = 4'b1000;
  logic [10:0] m_ctrl = '0;
  logic [4:0]  m_ev = '0;
  logic        m_rdy = 1'b1, m_irq = 1'b0, m_force = 1'b0;
  logic [15:0] m_rd = '0;

  always @(posedge clk) begin
    logic [3:0] rs, fl;
    logic [4:0] st, cl;
    logic cut, iss;
    logic [10:0] nc;
    if (rst) begin
      rawq.delete();
      m_s = 4'b1000; m_p = 4'b1000;
      m_ctrl = '0; m_ev = '0; m_rdy = 1; m_irq = 0; m_force = 0; m_rd = '0;
    end else begin
      rs = m_s & ~m_p;
      fl = ~m_s & m_p;
      st = {cmd_done_i, rs[3] | fl[3], rs[2] | fl[2], rs[1], rs[0]};
      cl = (wr_en && addr == 1) ? wdata[4:0] : 5'd0;
      if (rd_en) begin
        if (addr == 0)      m_rd = {5'd0, m_ctrl};
        else if (addr == 1) m_rd = {7'd0, m_ctrl[10], m_rdy, ~m_s[3], m_s[2], m_ev};
        else                m_rd = '0;
      end
      m_irq = m_ctrl[5] & |(m_ev & m_ctrl[4:0]);
      cut = rs[2] & m_ctrl[10];
      iss = wr_en && addr == 0 && (wdata[10:6] != m_ctrl[10:6]);
      nc = (wr_en && addr == 0) ? wdata[10:0] : m_ctrl;
      if (cut) nc[10] = 1'b0;
      m_ctrl = nc;
      m_force = cut;
      if (iss) m_rdy = 0;
      else if (cmd_done_i) m_rdy = 1;
      m_ev = (m_ev & ~cl) | st;
      m_p = m_s;
      rawq.push_front({prsnt_n_i, mrl_open_i, pfault_i, btn_i});
      if (rawq.size() > SS) void'(rawq.pop_back());
      m_s = (rawq.size() >= SS) ? rawq[SS-1] : 4'b1000;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 irq", 16'(irq), 16'(m_irq));
      chk("R8 slot_pwr_en", 16'(slot_pwr_en), 16'(m_ctrl[10]));
      chk("R8 pwr_force_off", 16'(pwr_force_off), 16'(m_force));
      chk("R7 indicators", {12'd0, attn_ind, pwr_ind}, {12'd0, m_ctrl[9:8], m_ctrl[7:6]});
      chk("R9 rdata", rdata, m_rd);
      if (pwr_force_off) force_cnt++;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); cmd_done_i = 1;
    @(negedge clk); cmd_done_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    // R1 reset state
    rd_chk(0, 16'h0000, "R1 ctrl after reset");
    rd_chk(1, 16'h0080, "R1 status after reset");
    chk("R1 irq after reset", 16'(irq), 16'h0);

    // R7 enables only: no command
    wr(0, 16'h003F);
    rd_chk(1, 16'h0080, "R7 ready kept on enable-only write");
    rd_chk(0, 16'h003F, "R7 ctrl readback");

    // R2 button edge
    @(negedge clk); btn_i = 1; idle(2); btn_i = 0; idle(8);
    rd_chk(1, 16'h0081, "R2 button event");
    chk("R6 irq on enabled event", 16'(irq), 16'h1);
    wr(1, 16'h0000);
    rd_chk(1, 16'h0081, "R5 zero write keeps event");
    wr(1, 16'h0001); idle(2);
    rd_chk(1, 16'h0080, "R5 one clears event");
    chk("R6 irq drops after clear", 16'(irq), 16'h0);

    // R2 power fault, per-event enable off
    wr(0, 16'h003D);
    @(negedge clk); pfault_i = 1; idle(8);
    rd_chk(1, 16'h0082, "R2 power fault event");
    chk("R6 irq masked by per-event enable", 16'(irq), 16'h0);
    wr(1, 16'h0002); idle(6);
    rd_chk(1, 16'h0080, "R2 held level does not re-set");
    pfault_i = 0; wr(0, 16'h003F);

    // R3 presence, active low
    @(negedge clk); prsnt_n_i = 0; idle(8);
    rd_chk(1, 16'h00C8, "R3 card inserted");
    wr(1, 16'h0008);
    @(negedge clk); prsnt_n_i = 1; idle(8);
    rd_chk(1, 16'h0088, "R3 card removed");
    wr(1, 16'h0008);

    // R7 / R4 command handshake
    wr(0, 16'h007F);
    rd_chk(1, 16'h0000, "R7 ready cleared by command");
    done_pulse(); idle(2);
    rd_chk(1, 16'h0090, "R4 command complete");
    chk("R6 irq on command event", 16'(irq), 16'h1);
    wr(1, 16'h0010);

    // R8 power on, then latch opens
    wr(0, 16'h047F); done_pulse(); wr(1, 16'h0010); idle(2);
    rd_chk(1, 16'h0180, "R8 power on status");
    chk("R8 slot power on", 16'(slot_pwr_en), 16'h1);
    @(negedge clk); mrl_open_i = 1; idle(8);
    rd_chk(1, 16'h00A4, "R8 latch open cuts power");
    rd_chk(0, 16'h007F, "R8 power bit cleared");
    chk("R8 one forced-off pulse", 16'(force_cnt), 16'h1);
    @(negedge clk); mrl_open_i = 0; idle(8);
    wr(1, 16'h0004);
    rd_chk(1, 16'h0080, "R3 latch closed");
    @(negedge clk); mrl_open_i = 1; idle(8);
    chk("R8 no pulse while off", 16'(force_cnt), 16'h1);
    @(negedge clk); mrl_open_i = 0; idle(8);
    wr(1, 16'h0004);

    // R5 set beats clear in the same cycle
    @(negedge clk); wr_en = 1; addr = 1; wdata = 16'h0010; cmd_done_i = 1;
    @(negedge clk); wr_en = 0; cmd_done_i = 0;
    rd_chk(1, 16'h0090, "R5 set wins over clear");
    wr(1, 16'h0010);

    // R9 unused addresses
    wr(3, 16'hFFFF);
    rd_chk(2, 16'h0000, "R9 unused address reads zero");
    rd_chk(0, 16'h007F, "R9 write to unused address ignored");
    rd_chk(1, 16'h0080, "R9 status untouched");

    // R6 global enable
    wr(0, 16'h005F);
    @(negedge clk); btn_i = 1; idle(2); btn_i = 0; idle(8);
    chk("R6 irq masked by global enable", 16'(irq), 16'h0);
    wr(0, 16'h007F); idle(2);
    chk("R6 irq with global enable", 16'(irq), 16'h1);
    idle(5);
    chk("R6 irq level held", 16'(irq), 16'h1);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule